// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one whole NAND flash operation after a single write of a control word. The word holds the first command byte, the number of address bytes, the data direction and the chip-enable choice. Setting its start bit begins the operation. The sequencer then performs each phase in turn:

- it sends the first command byte with CLE high;
- it sends the address bytes, least significant byte first, with ALE high;
- it moves the programmed number of data bytes between the flash bus and an internal byte buffer port;
- if enabled, it sends a confirm command byte taken from a secondary register.

Software programs the address, length, confirm-command and write-to-busy delay registers first, and then writes the control word. After the last bus cycle the sequencer waits out the programmed delay, then waits until the flash ready/busy line is high. It then sets a completion flag in a status register, which is cleared by writing one to the flag. A separate flag in the same register marks the end of the data phase.

Every flash byte cycle takes two clocks. In the first clock the strobe (WE# or RE#) is low. In the second clock the strobe is high, and a write strobe rises at the boundary between the two clocks. The bus value is held steady across that rising edge.

Top module: `nand_seq`

## Requirements
- R1: After reset the status register reads 0, `busy_o` is 0, both chip-enable outputs are high, WE# and RE# are high, and CLE and ALE are low.
- R2: A write to register 0 (control word) with bit 31 set starts an operation only while the sequencer is idle. A control write with bit 31 clear, or any control write while an operation is running, has no effect.
- R3: The first command byte is bits [7:0] of the control word and goes out with CLE high on the first WE# rise. The confirm byte is bits [7:0] of register 1 and goes out with CLE high after the address and data phases, only when bit 8 of register 1 is set.
- R4: Control bit 30 enables an address phase, and bits [29:27] hold the byte count minus one. The address bytes come from {register 3 (24 bits), register 2 (16 bits)}, least significant byte first, one per WE# rise with ALE high. CLE and ALE are never high together.
- R5: Control bit 26 selects a read data phase and bit 25 selects a write data phase; when both are set, read wins. The phase moves the register 4 count of bytes, one per strobe. Read byte k, sampled while RE# is low, is stored at buffer index k. Write byte k is taken from buffer index k. WE# and RE# are never low together.
- R6: Control bit 19 picks chip enable 1 (`nand_ce_no` = 2'b01) instead of chip enable 0 (2'b10) for the whole operation. Both enables are high while idle.
- R7: After the last bus cycle the sequencer waits (register 6 value + 1) clocks, then samples ready/busy each clock. The clock after it sees the line high, status bit 31 is set. An operation with n address bytes, d data bytes, c confirm bytes (0 or 1) and delay value T sets bit 31 on the (2+2n+2d+2c+T+2)-th clock edge after the edge that takes the control write.
- R8: Status bit 28 is set when the data phase of a read or write operation ends, including a zero-length one. It is not set by an operation without a data phase.
- R9: A write to register 5 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R10: `busy_o` is high from the clock after the start until the clock in which bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 control, 1 confirm, 2 address low, 3 address high, 4 length, 5 status, 6 delay) |
| reg_wdata_i | input | 32 | Register write data |
| irq_status_o | output | 32 | Status register: bit 31 operation done, bit 28 data phase done |
| busy_o | output | 1 | Operation in progress |
| nand_ce_no | output | 2 | Chip enables, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Bus value driven to flash |
| nand_io_oe_o | output | 1 | Bus drive enable |
| nand_io_i | input | 8 | Bus value from flash |
| nand_rb_i | input | 1 | Ready/busy from flash, high when ready |
| buf_idx_o | output | 12 | Buffer byte index for the data phase |
| buf_wr_o | output | 1 | Store `buf_wdata_o` at `buf_idx_o` |
| buf_wdata_o | output | 8 | Byte read from flash |
| buf_rdata_i | input | 8 | Buffer byte at `buf_idx_o`, for flash writes |

## Verification
Most faults in the phase state or the byte counter show up within one or two byte cycles as a wrong sequence on the flash pins. Examples are a missing or extra WE# rise, a byte latched with the wrong CLE/ALE qualifier, or address bytes in the wrong order. The bench logs these at each strobe edge. A fault in the delay timer or the ready wait moves the clock edge on which status bit 31 appears. The bench measures that edge exactly against the latency formula, and it also holds ready/busy low to show that completion waits for it. Faults in buffer indexing show up as wrong bytes in the bench buffer or wrong bytes on the bus once the data phase ends.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_ADDR, S_DATA, S_CMD2, S_TWB, S_WRB
  } seq_state_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CMD2 = 3'd1;
  localparam logic [2:0] RA_ALO  = 3'd2;
  localparam logic [2:0] RA_AHI  = 3'd3;
  localparam logic [2:0] RA_DLEN = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_TWB  = 3'd6;

  localparam int unsigned B_GO      = 31;
  localparam int unsigned B_APRES   = 30;
  localparam int unsigned B_RD      = 26;
  localparam int unsigned B_WR      = 25;
  localparam int unsigned B_CE1     = 19;
  localparam int unsigned B_CMD2EN  = 8;
  localparam int unsigned B_DONE    = 31;
  localparam int unsigned B_XFER    = 28;

  typedef struct packed {
    logic [7:0] cmd1;
    logic [7:0] cmd2;
    logic       cmd2_en;
    logic [3:0] n_addr;
    logic       rd;
    logic       wr;
    logic       ce1;
  } op_t;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int unsigned AHI_W   = 24,
  parameter int unsigned DLEN_W  = 12,
  parameter int unsigned TWB_W   = 8,
  parameter int unsigned TWB_RST = 4,
  localparam int unsigned ADDR_W = 16 + AHI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              idle_i,
  input  logic              set_cmd_i,
  input  logic              set_xfer_i,
  output logic              start_o,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DLEN_W-1:0] dlen_o,
  output logic [TWB_W-1:0]  twb_o,
  output logic [31:0]       status_o
);

  logic [7:0]        cmd2_q;
  logic              cmd2_en_q;
  logic [15:0]       alo_q;
  logic [AHI_W-1:0]  ahi_q;
  logic [DLEN_W-1:0] dlen_q;
  logic [TWB_W-1:0]  twb_q;
  logic              done_q, xfer_q;
  logic              clr_st;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign clr_st  = we_i && (addr_i == RA_STAT);
  assign start_o = we_i && (addr_i == RA_CTRL) && wdata_i[B_GO] && idle_i;

  always_comb begin
    op_o.cmd1    = wdata_i[7:0];
    op_o.cmd2    = cmd2_q;
    op_o.cmd2_en = cmd2_en_q;
    op_o.n_addr  = wdata_i[B_APRES] ? ({1'b0, wdata_i[29:27]} + 4'd1) : 4'd0;
    op_o.rd      = wdata_i[B_RD];
    op_o.wr      = wdata_i[B_WR] && !wdata_i[B_RD];
    op_o.ce1     = wdata_i[B_CE1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd2_q    <= '0;
      cmd2_en_q <= 1'b0;
      alo_q     <= '0;
      ahi_q     <= '0;
      dlen_q    <= '0;
      twb_q     <= TWB_W'(TWB_RST);
      done_q    <= 1'b0;
      xfer_q    <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_CMD2) begin
        cmd2_q    <= wdata_i[7:0];
        cmd2_en_q <= wdata_i[B_CMD2EN];
      end
      if (we_i && addr_i == RA_ALO)  alo_q  <= wdata_i[15:0];
      if (we_i && addr_i == RA_AHI)  ahi_q  <= wdata_i[AHI_W-1:0];
      if (we_i && addr_i == RA_DLEN) dlen_q <= wdata_i[DLEN_W-1:0];
      if (we_i && addr_i == RA_TWB)  twb_q  <= wdata_i[TWB_W-1:0];
      // a new event wins over a clear in the same cycle
      done_q <= set_cmd_i  | (done_q & ~(clr_st & wdata_i[B_DONE]));
      xfer_q <= set_xfer_i | (xfer_q & ~(clr_st & wdata_i[B_XFER]));
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[B_DONE] = done_q;
    status_o[B_XFER] = xfer_q;
  end

  assign addr_o = {ahi_q, alo_q};
  assign dlen_o = dlen_q;
  assign twb_o  = twb_q;

endmodule

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned DLEN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_t               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DLEN_W-1:0] dlen_i,
  input  logic              tmr_done_i,
  input  logic              rb_i,
  input  logic [7:0]        io_i,
  input  logic [7:0]        buf_rdata_i,
  output logic              tmr_load_o,
  output logic              cmd_done_o,
  output logic              xfer_done_o,
  output logic              busy_o,
  output logic [1:0]        ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  output logic [DLEN_W-1:0] buf_idx_o,
  output logic              buf_wr_o,
  output logic [7:0]        buf_wdata_o
);

  localparam logic [DLEN_W-1:0] ONE = DLEN_W'(1);

  seq_state_e        state_q, state_d, post_data, post_addr, post_cmd1;
  logic              phase_q;
  logic [DLEN_W-1:0] cnt_q, dlen_q;
  logic [ADDR_W-1:0] addr_q;
  op_t               op_q;
  logic              has_data, addr_last, data_last, byte_st, in_pre, drive_wr;

  always_comb begin
    has_data  = op_q.rd | op_q.wr;
    addr_last = (cnt_q + ONE) == DLEN_W'(op_q.n_addr);
    data_last = (cnt_q + ONE) == dlen_q;
    post_data = op_q.cmd2_en ? S_CMD2 : S_TWB;
    post_addr = (has_data && dlen_q != '0) ? S_DATA : post_data;
    post_cmd1 = (op_q.n_addr != 4'd0) ? S_ADDR : post_addr;
    state_d   = state_q;
    case (state_q)
      S_IDLE:  if (start_i) state_d = S_CMD1;
      S_CMD1:  if (phase_q) state_d = post_cmd1;
      S_ADDR:  if (phase_q && addr_last) state_d = post_addr;
      S_DATA:  if (phase_q && data_last) state_d = post_data;
      S_CMD2:  if (phase_q) state_d = S_TWB;
      S_TWB:   if (tmr_done_i) state_d = S_WRB;
      S_WRB:   if (rb_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign byte_st = (state_q == S_CMD1) || (state_q == S_ADDR) ||
                   (state_q == S_DATA) || (state_q == S_CMD2);
  assign in_pre  = (state_q == S_CMD1) || (state_q == S_ADDR) || (state_q == S_DATA);

  assign tmr_load_o  = (state_d == S_TWB) && (state_q != S_TWB);
  assign xfer_done_o = has_data && in_pre && ((state_d == S_CMD2) || (state_d == S_TWB));
  assign cmd_done_o  = (state_q == S_WRB) && rb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      dlen_q  <= '0;
      addr_q  <= '0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        phase_q <= 1'b0;
        cnt_q   <= '0;
        if (start_i) begin
          op_q   <= op_i;
          addr_q <= addr_i;
          dlen_q <= dlen_i;
        end
      end else if (byte_st) begin
        phase_q <= ~phase_q;
        if (phase_q) begin
          cnt_q <= (state_d != state_q) ? '0 : cnt_q + ONE;
          if (state_q == S_ADDR) addr_q <= addr_q >> 8;
        end
      end
    end
  end

  // pins: strobe low in phase 0, rises into phase 1 with bus held
  assign drive_wr = (state_q == S_DATA) && op_q.wr;
  assign busy_o   = (state_q != S_IDLE);
  assign ce_no    = !busy_o ? 2'b11 : (op_q.ce1 ? 2'b01 : 2'b10);
  assign cle_o    = (state_q == S_CMD1) || (state_q == S_CMD2);
  assign ale_o    = (state_q == S_ADDR);
  assign io_oe_o  = cle_o || ale_o || drive_wr;
  assign we_no    = !(io_oe_o && !phase_q);
  assign re_no    = !((state_q == S_DATA) && op_q.rd && !phase_q);

  always_comb begin
    case (state_q)
      S_CMD1:  io_o = op_q.cmd1;
      S_CMD2:  io_o = op_q.cmd2;
      S_ADDR:  io_o = addr_q[7:0];
      S_DATA:  io_o = drive_wr ? buf_rdata_i : 8'h00;
      default: io_o = 8'h00;
    endcase
  end

  assign buf_idx_o   = cnt_q;
  assign buf_wr_o    = (state_q == S_DATA) && op_q.rd && !phase_q;
  assign buf_wdata_o = io_i;

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int unsigned AHI_W   = 24,
  parameter int unsigned DLEN_W  = 12,
  parameter int unsigned TWB_W   = 8,
  parameter int unsigned TWB_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       irq_status_o,
  output logic              busy_o,
  output logic [1:0]        nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_io_o,
  output logic              nand_io_oe_o,
  input  logic [7:0]        nand_io_i,
  input  logic              nand_rb_i,
  output logic [DLEN_W-1:0] buf_idx_o,
  output logic              buf_wr_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);

  localparam int unsigned ADDR_W = 16 + AHI_W;

  logic              start, tmr_load, tmr_done, cmd_done, xfer_done;
  op_t               op;
  logic [ADDR_W-1:0] addr;
  logic [DLEN_W-1:0] dlen;
  logic [TWB_W-1:0]  twb;

  nand_seq_regs #(
    .AHI_W(AHI_W), .DLEN_W(DLEN_W), .TWB_W(TWB_W), .TWB_RST(TWB_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .idle_i     (!busy_o),
    .set_cmd_i  (cmd_done),
    .set_xfer_i (xfer_done),
    .start_o    (start),
    .op_o       (op),
    .addr_o     (addr),
    .dlen_o     (dlen),
    .twb_o      (twb),
    .status_o   (irq_status_o)
  );

  nand_seq_timer #(.W(TWB_W)) u_twb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (twb),
    .expired_o (tmr_done)
  );

  nand_seq_fsm #(.ADDR_W(ADDR_W), .DLEN_W(DLEN_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .op_i        (op),
    .addr_i      (addr),
    .dlen_i      (dlen),
    .tmr_done_i  (tmr_done),
    .rb_i        (nand_rb_i),
    .io_i        (nand_io_i),
    .buf_rdata_i (buf_rdata_i),
    .tmr_load_o  (tmr_load),
    .cmd_done_o  (cmd_done),
    .xfer_done_o (xfer_done),
    .busy_o      (busy_o),
    .ce_no       (nand_ce_no),
    .cle_o       (nand_cle_o),
    .ale_o       (nand_ale_o),
    .we_no       (nand_we_no),
    .re_no       (nand_re_no),
    .io_o        (nand_io_o),
    .io_oe_o     (nand_io_oe_o),
    .buf_idx_o   (buf_idx_o),
    .buf_wr_o    (buf_wr_o),
    .buf_wdata_o (buf_wdata_o)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [2:0] reg_addr_i,
  input logic       wd_go_i,
  input logic       wd_xfer_i,
  input logic       st_done_i,
  input logic       st_xfer_i,
  input logic       busy_i,
  input logic [1:0] ce_ni,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_ni,
  input logic       re_ni,
  input logic       oe_i,
  input logic       rb_i
);

  AST_CE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_ni)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (ce_ni == 2'b11) && we_ni && re_ni && !oe_i && !cle_i && !ale_i); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_ni && !re_ni)); // R5

  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_i && ale_i)); // R4

  AST_DONE_AFTER_RB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_done_i) |-> $past(rb_i)); // R7

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0 && wd_go_i && !busy_i) |=> busy_i); // R2

  AST_XFER_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd5 && wd_xfer_i && !busy_i) |=> !st_xfer_i); // R9

endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wd_go_i    (reg_wdata_i[31]),
  .wd_xfer_i  (reg_wdata_i[28]),
  .st_done_i  (irq_status_o[31]),
  .st_xfer_i  (irq_status_o[28]),
  .busy_i     (busy_o),
  .ce_ni      (nand_ce_no),
  .cle_i      (nand_cle_o),
  .ale_i      (nand_ale_o),
  .we_ni      (nand_we_no),
  .re_ni      (nand_re_no),
  .oe_i       (nand_io_oe_o),
  .rb_i       (nand_rb_i)
);

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GO = 32'h8000_0000, APRES = 32'h4000_0000,
                          RD = 32'h0400_0000, WR = 32'h0200_0000, CE1 = 32'h0008_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status;
  logic        busy, cle, ale, we_n, re_n, io_oe, buf_wr, rb = 1'b1;
  logic [1:0]  ce_n;
  logic [7:0]  io_o, io_i, buf_wdata, buf_rdata;
  logic [11:0] buf_idx;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem [0:63];
  logic [7:0] cmd_log [0:63], adr_log [0:63], wr_log [0:63];
  int n_cmd = 0, n_adr = 0, n_wr = 0, rd_n = 0;
  logic [1:0] ce_we = 2'b11, ce_re = 2'b11;

  nand_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .irq_status_o(status), .busy_o(busy),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_io_o(io_o), .nand_io_oe_o(io_oe), .nand_io_i(io_i),
    .nand_rb_i(rb), .buf_idx_o(buf_idx), .buf_wr_o(buf_wr),
    .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata)
  );

  // flash and buffer models
  assign io_i      = 8'hA0 + rd_n[7:0];
  assign buf_rdata = mem[buf_idx[5:0]];
  always @(posedge clk) if (buf_wr) mem[buf_idx[5:0]] <= buf_wdata;
  always @(negedge re_n) begin rd_n = rd_n + 1; ce_re = ce_n; end
  always @(posedge we_n) begin
    ce_we = ce_n;
    if (cle)      begin cmd_log[n_cmd[5:0]] = io_o; n_cmd = n_cmd + 1; end
    else if (ale) begin adr_log[n_adr[5:0]] = io_o; n_adr = n_adr + 1; end
    else          begin wr_log[n_wr[5:0]]   = io_o; n_wr  = n_wr + 1;  end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!status[31] && k < 2000);
  endtask

  task automatic t_reset;
    check(status == 32'h0, "R1", "status", status, 0);
    check(ce_n == 2'b11 && we_n && re_n && !cle && !ale && !busy, "R1", "idle pins",
          {ce_n, we_n, re_n, cle, ale, busy}, 7'b1111000);
  endtask

  task automatic t_page_write;
    int k, c0, a0, w0;
    logic [39:0] a = 40'h78_5634_3412;
    for (int i = 0; i < 8; i++) mem[i] <= 8'h50 + 8'(i);
    wr_reg(5, 32'hFFFF_FFFF); wr_reg(6, 3);
    wr_reg(2, 32'h3412); wr_reg(3, 32'h785634); wr_reg(4, 4); wr_reg(1, 32'h110);
    c0 = n_cmd; a0 = n_adr; w0 = n_wr;
    wr_reg(0, GO | APRES | (32'd4 << 27) | WR | 32'h80);
    check(busy, "R10", "busy after start", busy, 1);
    wait_done(k);
    check(k == 27, "R7", "page write latency", k, 27);
    check(n_cmd - c0 == 2 && cmd_log[c0[5:0]] == 8'h80 && cmd_log[6'(c0 + 1)] == 8'h10,
          "R3", "command bytes", {cmd_log[c0[5:0]], cmd_log[6'(c0 + 1)]}, 16'h8010);
    check(n_adr - a0 == 5, "R4", "address count", n_adr - a0, 5);
    for (int i = 0; i < 5; i++)
      check(adr_log[6'(a0 + i)] == a[8*i +: 8], "R4", "address byte",
            adr_log[6'(a0 + i)], a[8*i +: 8]);
    check(n_wr - w0 == 4, "R5", "write byte count", n_wr - w0, 4);
    for (int i = 0; i < 4; i++)
      check(wr_log[6'(w0 + i)] == 8'h50 + 8'(i), "R5", "write data",
            wr_log[6'(w0 + i)], 8'h50 + i);
    check(ce_we == 2'b10, "R6", "ce0 selected", ce_we, 2'b10);
    check(status[28], "R8", "xfer flag after write", status[28], 1);
    @(negedge clk);
    check(!busy, "R10", "busy cleared", busy, 0);
  endtask

  task automatic t_read_id;
    int k, c0, a0, w0, r0;
    wr_reg(5, 32'hFFFF_FFFF); wr_reg(2, 0); wr_reg(3, 0); wr_reg(4, 4); wr_reg(1, 32'h030);
    c0 = n_cmd; a0 = n_adr; w0 = n_wr; r0 = rd_n;
    wr_reg(0, GO | APRES | RD | WR | CE1 | 32'h90);
    wait_done(k);
    check(k == 17, "R7", "read latency", k, 17);
    check(n_cmd - c0 == 1 && cmd_log[c0[5:0]] == 8'h90, "R3", "no confirm when disabled",
          n_cmd - c0, 1);
    check(n_adr - a0 == 1 && adr_log[a0[5:0]] == 8'h00, "R4", "single address byte",
          n_adr - a0, 1);
    check(n_wr == w0, "R5", "read wins over write", n_wr - w0, 0);
    for (int i = 0; i < 4; i++)
      check(mem[i] == 8'(8'hA1 + r0 + i), "R5", "read byte stored",
            mem[i], 8'(8'hA1 + r0 + i));
    check(ce_re == 2'b01, "R6", "ce1 selected", ce_re, 2'b01);
    check(status[28], "R8", "xfer flag after read", status[28], 1);
  endtask

  task automatic t_erase;
    int k, c0, a0;
    wr_reg(5, 32'hFFFF_FFFF); wr_reg(2, 32'h0200); wr_reg(3, 1); wr_reg(1, 32'h1D0);
    c0 = n_cmd; a0 = n_adr;
    wr_reg(0, GO | APRES | (32'd2 << 27) | 32'h60);
    wait_done(k);
    check(k == 15, "R7", "erase latency", k, 15);
    check(cmd_log[c0[5:0]] == 8'h60 && cmd_log[6'(c0 + 1)] == 8'hD0, "R3", "erase pair",
          {cmd_log[c0[5:0]], cmd_log[6'(c0 + 1)]}, 16'h60D0);
    check({adr_log[a0[5:0]], adr_log[6'(a0 + 1)], adr_log[6'(a0 + 2)]} == 24'h000201,
          "R4", "erase address order",
          {adr_log[a0[5:0]], adr_log[6'(a0 + 1)], adr_log[6'(a0 + 2)]}, 24'h000201);
    check(!status[28], "R8", "no xfer flag without data", status[28], 0);
  endtask

  task automatic t_zero_len_w1c;
    int k, w0;
    wr_reg(5, 32'hFFFF_FFFF); wr_reg(4, 0); wr_reg(1, 0);
    w0 = n_wr;
    wr_reg(0, GO | WR | 32'h85);
    wait_done(k);
    check(k == 7, "R7", "zero length latency", k, 7);
    check(n_wr == w0, "R5", "zero length moves nothing", n_wr - w0, 0);
    check(status[28], "R8", "zero length xfer flag", status[28], 1);
    wr_reg(5, 32'h8000_0000);
    check(status == 32'h1000_0000, "R9", "clear done only", status, 32'h1000_0000);
    wr_reg(5, 32'h0);
    check(status == 32'h1000_0000, "R9", "zero write keeps", status, 32'h1000_0000);
    wr_reg(5, 32'h1000_0000);
    check(status == 32'h0, "R9", "clear xfer", status, 0);
  endtask

  task automatic t_ignore;
    int k, c0;
    c0 = n_cmd;
    wr_reg(0, 32'h0000_00FF);
    check(!busy, "R2", "no start without go bit", busy, 0);
    repeat (5) @(negedge clk);
    check(n_cmd == c0 && status == 0, "R2", "nothing issued", n_cmd - c0, 0);
    wr_reg(6, 40); wr_reg(1, 0);
    wr_reg(0, GO | 32'hFF);
    repeat (6) @(negedge clk);
    wr_reg(0, GO | 32'h70);
    wait_done(k);
    repeat (8) @(negedge clk);
    check(n_cmd - c0 == 1 && cmd_log[c0[5:0]] == 8'hFF, "R2", "write while busy ignored",
          n_cmd - c0, 1);
    check(!busy, "R10", "idle after single op", busy, 0);
    wr_reg(6, 3);
  endtask

  task automatic t_rb_wait;
    int k;
    wr_reg(5, 32'hFFFF_FFFF); wr_reg(6, 2);
    rb = 1'b0;
    wr_reg(0, GO | 32'hFF);
    repeat (30) @(negedge clk);
    check(!status[31], "R7", "done held off by busy line", status[31], 0);
    check(busy, "R10", "busy while flash busy", busy, 1);
    rb = 1'b1;
    wait_done(k);
    check(k == 1, "R7", "done one edge after ready", k, 1);
    wr_reg(6, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_write();
    t_read_id();
    t_erase();
    t_zero_len_w1c();
    t_ignore();
    t_rb_wait();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule